// File: doc/BRIEF.md
# GF(2^8) Constant Region Multiplier

This block multiplies a stream of data words by a single constant in the finite field GF(2^8). Each 128-bit beat carries sixteen independent byte lanes, and every lane is replaced by its field product with the current constant. It sits on the encode or rebuild path of an erasure-coding engine, where whole regions of bytes are scaled by one coefficient before they are combined elsewhere.

The multiply does not use a general-purpose multiplier in the datapath. When a new constant is loaded, the block spends sixteen cycles filling two 16-entry byte tables. One table holds the constant times each possible low nibble. The other holds the constant times each possible high nibble placed in the upper half of a byte. Each lane then needs only two table reads and one XOR. Input and output use valid/ready handshakes, and results leave in the order the beats arrived.

Top module: `gf8_region_mul`

## Requirements
- R1: After reset, out_valid is 0, and in_ready stays 0 until a constant has been loaded with load_const.
- R2: A load_const pulse samples const_y on that clock edge. in_ready is 0 for the 16 cycles that follow. If the output side is not stalled, in_ready is 1 after the 16th following edge.
- R3: Each lane i, which is bits [8i+7:8i] of the data word, leaves as y·a in GF(2^8). The reduction polynomial is x^8+x^4+x^3+x^2+1 (0x11D). This holds for all 16 lanes and every byte value.
- R4: The low table holds y·n and the high table holds y·(n<<4), with n = 0..15. The two tables hold full field products and are not shifted copies of each other. With y=0x07, an input byte 0x0A gives 0x36 and an input byte 0xA0 gives 0x47.
- R5: A constant of 0x00 gives an all-zero output word. A constant of 0x01 returns the input word unchanged.
- R6: Suppose a beat is accepted on edge k and out_ready is high on edge k+1. Then out_valid is 0 after edge k and 1 after edge k+1, with the product on out_data.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable. Across any pattern of stalls, no beat is lost, duplicated or reordered.
- R8: A beat accepted before a load_const pulse, or on the same edge as it, is multiplied by the previous constant.
- R9: A load_const pulse during a table fill restarts the fill with the new constant. in_ready then stays 0 for 16 cycles from the latest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_const | input | 1 | One-cycle pulse that starts a table fill for const_y |
| const_y | input | 8 | Field constant to multiply by |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | 128 | Sixteen input bytes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts an output beat |
| out_data | output | 128 | Sixteen product bytes |

## Verification
The constant 0x07 is tried with lanes holding 0x0A and 0xA0. This shows whether the high table holds true field products rather than a nibble-shifted copy of the low table. The constants 0x00 and 0x01 separate a table that was never written from a wrong index path. One random constant is run against all 256 byte values spread over the lanes, which exposes reduction-polynomial and lane-swap faults. Random constants and data under random output stalls, with reloads issued mid-stream and on the same edge as an input beat, show whether beats are lost or reordered and which constant each beat picks up.

// File: rtl/gf8_pkg.sv
// Shared field types and helpers for the GF(2^8) region multiplier.
// Assumes bytes split into two 4-bit nibbles and a 16-entry table per nibble.
package gf8_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned TBL_DEPTH = 16;

    typedef logic [BYTE_W-1:0] gf_byte_t;
    typedef logic [TBL_DEPTH-1:0][BYTE_W-1:0] nib_tbl_t;

    // Field product of a and b, reducing by x^8 plus the polynomial in red_lo.
    function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b,
                                        input gf_byte_t red_lo);
        gf_byte_t acc;
        gf_byte_t run;
        acc = '0;
        run = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ run;
            run = run[BYTE_W-1] ? ((run << 1) ^ red_lo) : (run << 1);
        end
        return acc;
    endfunction
endpackage

// File: rtl/gf8_table_fill.sv
// Builds the low and high nibble product tables for the loaded constant.
// The fill writes one entry of each table per cycle for 16 cycles.
// A new load pulse restarts the fill. tbl_ready rises once the last entry is written.
module gf8_table_fill
    import gf8_pkg::*;
#(
    parameter gf_byte_t RED_POLY = 8'h1D
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_const,
    input  gf_byte_t const_y,
    output nib_tbl_t lo_tbl,
    output nib_tbl_t hi_tbl,
    output logic     tbl_ready
);
    localparam logic [NIB_W-1:0] LAST_IDX = NIB_W'(TBL_DEPTH - 1);

    gf_byte_t         y_q;
    logic [NIB_W-1:0] fill_idx;
    logic             filling;
    gf_byte_t         lo_next;
    gf_byte_t         hi_next;

    // Products for the entry being written this cycle.
    always_comb begin
        lo_next = gf_mul(y_q, {{(BYTE_W-NIB_W){1'b0}}, fill_idx}, RED_POLY);
        hi_next = gf_mul(y_q, {fill_idx, {(BYTE_W-NIB_W){1'b0}}}, RED_POLY);
    end

    // Fill sequencer: latch constant, step index, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q       <= '0;
            fill_idx  <= '0;
            filling   <= 1'b0;
            tbl_ready <= 1'b0;
        end else if (load_const) begin
            y_q       <= const_y;
            fill_idx  <= '0;
            filling   <= 1'b1;
            tbl_ready <= 1'b0;
        end else if (filling) begin
            fill_idx <= fill_idx + 1'b1;
            if (fill_idx == LAST_IDX) begin
                filling   <= 1'b0;
                tbl_ready <= 1'b1;
            end
        end
    end

    // Table storage: write the indexed entry of both tables while filling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_tbl <= '0;
            hi_tbl <= '0;
        end else if (filling && !load_const) begin
            for (int e = 0; e < TBL_DEPTH; e++) begin
                if (fill_idx == NIB_W'(e)) begin
                    lo_tbl[e] <= lo_next;
                    hi_tbl[e] <= hi_next;
                end
            end
        end
    end
endmodule

// File: rtl/gf8_lane_lookup.sv
// One byte lane: reads the low table with the low nibble and the high table
// with the high nibble. Purely combinational. The caller XORs the two parts.
module gf8_lane_lookup
    import gf8_pkg::*;
(
    input  nib_tbl_t lo_tbl,
    input  nib_tbl_t hi_tbl,
    input  gf_byte_t byte_in,
    output gf_byte_t lo_part,
    output gf_byte_t hi_part
);
    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;

    // Split the byte into its two table indices.
    always_comb begin
        lo_nib  = byte_in[NIB_W-1:0];
        hi_nib  = byte_in[BYTE_W-1:NIB_W];
        lo_part = lo_tbl[lo_nib];
        hi_part = hi_tbl[hi_nib];
    end
endmodule

// File: rtl/gf8_mul_pipe.sv
// Two-stage valid/ready pipeline. Stage 1 captures the table reads at
// acceptance, so a later reload cannot affect beats in flight. Stage 2 holds
// the XOR of the two parts. The whole pipe stalls when stage 2 is held.
module gf8_mul_pipe #(
    parameter int unsigned DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_ready,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] lo_vec,
    input  logic [DATA_W-1:0] hi_vec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              advance;
    logic              s1_valid;
    logic [DATA_W-1:0] s1_lo;
    logic [DATA_W-1:0] s1_hi;

    // Pipe moves when the output register is empty or being drained.
    always_comb begin
        advance  = !out_valid || out_ready;
        in_ready = tbl_ready && advance;
    end

    // Stage 1: register both table reads of an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_lo    <= '0;
            s1_hi    <= '0;
        end else if (advance) begin
            s1_valid <= in_valid && tbl_ready;
            if (in_valid && tbl_ready) begin
                s1_lo <= lo_vec;
                s1_hi <= hi_vec;
            end
        end
    end

    // Stage 2: combine the parts into the product word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            if (s1_valid) out_data <= s1_lo ^ s1_hi;
        end
    end
endmodule

// File: rtl/gf8_region_mul.sv
// Top level: multiplies every byte of each 128-bit beat by a loaded GF(2^8)
// constant using two nibble tables. Assumes load_const is a single-cycle
// pulse. No beat is accepted until the first table fill completes.
module gf8_region_mul
    import gf8_pkg::*;
#(
    parameter int unsigned LANES    = 16,
    parameter gf_byte_t    RED_POLY = 8'h1D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_const,
    input  logic [BYTE_W-1:0]       const_y,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*BYTE_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*BYTE_W-1:0] out_data
);
    localparam int unsigned DATA_W = LANES * BYTE_W;

    nib_tbl_t          lo_tbl;
    nib_tbl_t          hi_tbl;
    logic              tbl_ready;
    logic [DATA_W-1:0] lo_vec;
    logic [DATA_W-1:0] hi_vec;

    gf8_table_fill #(.RED_POLY(RED_POLY)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_const (load_const),
        .const_y    (const_y),
        .lo_tbl     (lo_tbl),
        .hi_tbl     (hi_tbl),
        .tbl_ready  (tbl_ready)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        gf8_lane_lookup u_lane (
            .lo_tbl  (lo_tbl),
            .hi_tbl  (hi_tbl),
            .byte_in (in_data[i*BYTE_W +: BYTE_W]),
            .lo_part (lo_vec[i*BYTE_W +: BYTE_W]),
            .hi_part (hi_vec[i*BYTE_W +: BYTE_W])
        );
    end

    gf8_mul_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_ready (tbl_ready),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .lo_vec    (lo_vec),
        .hi_vec    (hi_vec),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/gf8_region_mul_chk.sv
// Protocol checker for gf8_region_mul, attached with bind. It tracks at its
// ports whether a constant has been seen and how many cycles have passed
// since the latest load pulse.
module gf8_region_mul_chk #(
    parameter int unsigned DATA_W      = 128,
    parameter int unsigned FILL_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_const,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int unsigned CNT_W = $clog2(FILL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILL_CYCLES);

    logic             seen_load;
    logic [CNT_W-1:0] since_load;

    // Count cycles since the latest load pulse, saturating at the fill length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_load  <= 1'b0;
            since_load <= CNT_MAX;
        end else if (load_const) begin
            seen_load  <= 1'b1;
            since_load <= '0;
        end else if (since_load != CNT_MAX) begin
            since_load <= since_load + 1'b1;
        end
    end

    AST_NO_INPUT_BEFORE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> !in_ready); // R1
    AST_NO_OUTPUT_BEFORE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> !out_valid); // R1
    AST_FILL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && since_load != CNT_MAX) |-> !in_ready); // R2
    AST_OUT_HELD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready |=> out_valid); // R6
endmodule

bind gf8_region_mul gf8_region_mul_chk #(.DATA_W(LANES*8), .FILL_CYCLES(16)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_const (load_const),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/gf8_region_mul_bench.sv
`timescale 1ns/1ps
module gf8_region_mul_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_const = 1'b0;
    logic [7:0]   const_y = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;

    int unsigned  n_checks = 0;
    int unsigned  n_fails = 0;
    logic [7:0]   y_model = '0;
    logic [127:0] exp_q[$];
    logic [127:0] last_out = '0;
    logic         stall_en = 1'b0;
    logic         hold_off = 1'b0;

    always #2.5 clk = ~clk;

    gf8_region_mul u_gf8_region_mul (
        .clk(clk), .rst_n(rst_n), .load_const(load_const), .const_y(const_y),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Reference: carry-less product, then long division by 0x11D.
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
        for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'(9'h11D) << (k - 8));
        return p[7:0];
    endfunction

    function automatic logic [127:0] ref_word(input logic [7:0] y, input logic [127:0] d);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = ref_mul(d[i*8 +: 8], y);
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Output-ready driver, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        out_ready <= hold_off ? 1'b0 : (stall_en ? ($urandom % 3 != 0) : 1'b1);
    end

    // Monitor: compare each transferring beat with the scoreboard head (R3, R7).
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            last_out = out_data;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 extra beat", out_data, '0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R3 lane products", out_data, e);
            end
        end
    end

    task automatic send(input logic [127:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        forever begin
            #1;
            if (in_ready) begin
                exp_q.push_back(ref_word(y_model, d));
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load_y(input logic [7:0] y, input logic check_fill);
        @(negedge clk);
        load_const = 1'b1;
        const_y    = y;
        @(negedge clk);
        load_const = 1'b0;
        y_model    = y;
        if (check_fill) begin
            #1 check(!in_ready, "R2 fill blocks input", 128'(in_ready), 0);
            for (int i = 2; i <= 16; i++) begin
                @(negedge clk);
                #1 check(!in_ready, "R2 fill blocks input", 128'(in_ready), 0);
            end
            @(negedge clk);
            #1 check(in_ready, "R2 ready after fill", 128'(in_ready), 1);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [127:0] d;
        logic [127:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and no acceptance without a constant.
        #1 check(!in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 0);
        repeat (4) @(negedge clk);
        #1 check(!in_ready, "R1 no constant yet", 128'(in_ready), 0);

        // R2 and R4: fill timing and the y=7 example values.
        load_y(8'h07, 1'b1);
        d = 128'h0F1E2D3C4B5A69788796A5B4C3D2_A00A;
        send(d);
        idle();
        drain();
        check(last_out[7:0] == 8'h36, "R4 7*0x0A", 128'(last_out[7:0]), 128'h36);
        check(last_out[15:8] == 8'h47, "R4 7*0xA0", 128'(last_out[15:8]), 128'h47);

        // R6: exact latency with no stall.
        send(128'h0123456789ABCDEFFEDCBA9876543210);
        @(negedge clk);
        in_valid = 1'b0;
        #1 check(!out_valid, "R6 not valid after accept edge", 128'(out_valid), 0);
        @(negedge clk);
        #1 check(out_valid, "R6 valid after next edge", 128'(out_valid), 1);
        drain();

        // R5: zero and identity constants.
        load_y(8'h00, 1'b0);
        d = {$urandom, $urandom, $urandom, $urandom};
        send(d);
        idle();
        drain();
        check(last_out == '0, "R5 zero constant", last_out, '0);
        load_y(8'h01, 1'b0);
        send(d);
        idle();
        drain();
        check(last_out == d, "R5 identity constant", last_out, d);

        // R3: every byte value once, under a random constant.
        load_y(8'($urandom | 2), 1'b0);
        for (int b = 0; b < 16; b++) begin
            for (int l = 0; l < 16; l++) d[l*8 +: 8] = 8'(b * 16 + ((l * 7) % 16));
            send(d);
        end
        idle();
        drain();

        // R8: beat on the same edge as a reload keeps the old constant.
        load_y(8'h53, 1'b0);
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        d = 128'h11111111222222223333333344444444;
        load_const = 1'b1;
        const_y    = 8'hC4;
        in_valid   = 1'b1;
        in_data    = d;
        #1 check(in_ready, "R8 accepted with reload", 128'(in_ready), 1);
        exp_q.push_back(ref_word(8'h53, d));
        @(negedge clk);
        load_const = 1'b0;
        in_valid   = 1'b0;
        y_model    = 8'hC4;
        drain();
        check(last_out == ref_word(8'h53, d), "R8 old constant used", last_out, ref_word(8'h53, d));
        send(d);
        idle();
        drain();
        check(last_out == ref_word(8'hC4, d), "R8 new constant after", last_out, ref_word(8'hC4, d));

        // R9: reload mid-fill restarts the fill with the newer constant.
        load_y(8'h9E, 1'b0);
        repeat (5) @(negedge clk);
        load_y(8'h2B, 1'b1);
        d = 128'hDEADBEEF0123456789ABCDEFCAFEF00D;
        send(d);
        idle();
        drain();
        check(last_out == ref_word(8'h2B, d), "R9 restarted constant", last_out, ref_word(8'h2B, d));

        // R7: output held stable while stalled.
        hold_off = 1'b1;
        @(posedge clk);
        send(128'hA5A5A5A55A5A5A5A0F0F0F0FF0F0F0F0);
        send(128'h00112233445566778899AABBCCDDEEFF);
        idle();
        @(negedge clk);
        #1 check(out_valid, "R7 valid while stalled", 128'(out_valid), 1);
        snap = out_data;
        repeat (3) @(negedge clk);
        #1 check(out_valid && out_data == snap, "R7 data stable", out_data, snap);
        check(!in_ready, "R7 full pipe blocks input", 128'(in_ready), 0);
        hold_off = 1'b0;
        drain();

        // R3 and R7: random constants and data under random stalls.
        stall_en = 1'b1;
        for (int c = 0; c < 20; c++) begin
            load_y(8'($urandom), 1'b0);
            for (int n = 0; n < 30; n++) send({$urandom, $urandom, $urandom, $urandom});
            idle();
        end
        drain();
        stall_en = 1'b0;
        check(exp_q.size() == 0, "R7 no lost beats", 128'(exp_q.size()), 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule